// File: doc/BRIEF.md
# Shift/Load Register with JK First-Stage Entry

This block is a small synchronous register of `WIDTH` stages (four by default). On every rising clock edge it does one of two things. When `shift_en` is low it captures a parallel word. When `shift_en` is high it moves its contents one stage further from the first stage toward the last. During a shift, the new value of the first stage comes from a J/K rule. This lets that stage behave as a JK, D or T flip-flop, depending on how `j_in` and `k_in` are tied.

An active-low clear overrides everything else and empties the register at once, without waiting for a clock edge. Every stage value is available at the outputs, and the last stage is also given in inverted form. The parameter `K_ACTIVE_LOW` flips the sense of `k_in`. With that parameter set, driving J and K from the same signal gives D-type entry.

Top module: `shreg_jk`

## Requirements
- R1: While `clr_n` is low, every bit of `q` is 0, and a falling `clr_n` clears `q` before the next rising clock edge.
- R2: While `clr_n` is low, rising clock edges leave `q` at 0 whatever `shift_en`, `par_d`, `j_in` and `k_in` carry.
- R3: A rising edge with `shift_en` low loads `par_d` into `q`, with `par_d[i]` going to `q[i]`; `q[0]` is the first stage.
- R4: During a parallel load, `j_in` and `k_in` have no effect on the loaded value.
- R5: A rising edge with `shift_en` high sets `q[i]` to the previous `q[i-1]` for every i from 1 to WIDTH-1.
- R6: During a shift, with K active-high, `q[0]` is updated from {j_in,k_in}: 00 holds it, 10 sets it, 01 clears it, 11 toggles it.
- R7: `q_last_n` always equals the inverse of `q[WIDTH-1]`.
- R8: With `K_ACTIVE_LOW`=1, the first stage uses the inverse of `k_in` in the R6 rule, so tying `j_in` and `k_in` to one data bit shifts that bit into `q[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low, highest priority |
| shift_en | input | 1 | 1 = shift toward the last stage, 0 = parallel load |
| par_d | input | WIDTH | Parallel data; bit i loads stage i |
| j_in | input | 1 | J serial entry for the first stage |
| k_in | input | 1 | K serial entry for the first stage (sense set by K_ACTIVE_LOW) |
| q | output | WIDTH | Stage values, bit 0 is the first stage |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
A load or a shift shows on `q` one rising edge after the inputs that requested it. The bench therefore drives inputs on a falling edge and compares `q` on the following falling edge, half a period after the register updated. Clear is the one result due with no edge at all. It is checked 1 ns after `clr_n` falls, in the middle of the clock low phase, so no rising edge could have produced the zero. `q_last_n` is combinational from the last stage and is compared at the same sampling points as `q`.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  // First-stage operation selected by {J, K_effective}
  typedef enum logic [1:0] {
    JK_HOLD = 2'b00,
    JK_CLR  = 2'b01,
    JK_SET  = 2'b10,
    JK_TOG  = 2'b11
  } jk_op_e;

  function automatic logic jk_next(input logic cur, input jk_op_e op);
    logic nxt;
    case (op)
      JK_HOLD: nxt = cur;
      JK_CLR:  nxt = 1'b0;
      JK_SET:  nxt = 1'b1;
      default: nxt = ~cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/jk_entry_stage.sv
module jk_entry_stage
  import shreg_pkg::*;
#(
  parameter bit K_ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic clr_n,
  input  logic shift_en,
  input  logic j_in,
  input  logic k_in,
  input  logic par_bit,
  output logic q_out
);

  logic   k_eff;
  jk_op_e op;

  generate
    if (K_ACTIVE_LOW) begin : g_k_low
      assign k_eff = ~k_in;
    end else begin : g_k_high
      assign k_eff = k_in;
    end
  endgenerate

  assign op = jk_op_e'({j_in, k_eff});

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)        q_out <= 1'b0;
    else if (!shift_en) q_out <= par_bit;
    else               q_out <= jk_next(q_out, op);
  end

  // R6 / R8: first-stage J/K behaviour during a shift
  a_r6_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && !j_in && !k_eff) |=> $stable(q_out));
  a_r6_set: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && j_in && !k_eff) |=> q_out);
  a_r6_clr: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && !j_in && k_eff) |=> !q_out);
  a_r6_tog: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && j_in && k_eff) |=> (q_out != $past(q_out)));
  // R4: load ignores J/K
  a_r4_load_first: assert property (@(posedge clk) disable iff (!clr_n)
    !shift_en |=> (q_out == $past(par_bit)));

endmodule

// File: rtl/shift_cell.sv
module shift_cell (
  input  logic clk,
  input  logic clr_n,
  input  logic shift_en,
  input  logic prev_bit,
  input  logic par_bit,
  output logic q_out
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   q_out <= 1'b0;
    else if (shift_en) q_out <= prev_bit;
    else          q_out <= par_bit;
  end

  // R5: shift takes the neighbour's previous value
  a_r5_cell_shift: assert property (@(posedge clk) disable iff (!clr_n)
    shift_en |=> (q_out == $past(prev_bit)));

endmodule

// File: rtl/shreg_jk.sv
module shreg_jk #(
  parameter int unsigned WIDTH        = 4,
  parameter bit          K_ACTIVE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] par_d,
  input  logic             j_in,
  input  logic             k_in,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);

  localparam int unsigned LAST = WIDTH - 1;

  jk_entry_stage #(.K_ACTIVE_LOW(K_ACTIVE_LOW)) u_head (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_en (shift_en),
    .j_in     (j_in),
    .k_in     (k_in),
    .par_bit  (par_d[0]),
    .q_out    (q[0])
  );

  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_cell
      shift_cell u_cell (
        .clk      (clk),
        .clr_n    (clr_n),
        .shift_en (shift_en),
        .prev_bit (q[i-1]),
        .par_bit  (par_d[i]),
        .q_out    (q[i])
      );
    end
  endgenerate

  assign q_last_n = ~q[LAST];

  // R1 / R2: clear holds the whole register at zero
  a_r1_clear_zero: assert property (@(posedge clk)
    !clr_n |-> (q == '0));
  // R3: parallel load captures the word
  a_r3_load_word: assert property (@(posedge clk) disable iff (!clr_n)
    !shift_en |=> (q == $past(par_d)));
  // R5: whole-register shift toward the last stage
  a_r5_shift_word: assert property (@(posedge clk) disable iff (!clr_n)
    shift_en |=> (q[LAST:1] == $past(q[LAST-1:0])));

endmodule

// File: tb/tb_shreg_jk.sv
module tb_shreg_jk;

  localparam int W = 4;

  logic clk = 1'b0;
  logic clr_n = 1'b1;
  logic shift_en = 1'b0, j_in = 1'b0, k_in = 1'b0;
  logic [W-1:0] par_d = '0;
  logic [W-1:0] q;
  logic q_last_n;
  // second instance, K active-low
  logic shift2 = 1'b0, din2 = 1'b0;
  logic [W-1:0] q2;
  logic q2_last_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shreg_jk #(.WIDTH(W), .K_ACTIVE_LOW(1'b0)) dut (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .par_d(par_d),
    .j_in(j_in), .k_in(k_in), .q(q), .q_last_n(q_last_n));

  shreg_jk #(.WIDTH(W), .K_ACTIVE_LOW(1'b1)) dut_kl (
    .clk(clk), .clr_n(clr_n), .shift_en(shift2), .par_d('0),
    .j_in(din2), .k_in(din2), .q(q2), .q_last_n(q2_last_n));

  // {req[3:0], shift_en, j, k, par_d[3:0], expected q[3:0]}
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {4'd3, 1'b0, 1'b0, 1'b0, 4'b1010, 4'b1010}, // R3 load
    {4'd4, 1'b0, 1'b1, 1'b1, 4'b0101, 4'b0101}, // R4 load ignores J/K
    {4'd6, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1011}, // R6 hold, R5 shift
    {4'd6, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b0111}, // R6 set
    {4'd6, 1'b1, 1'b0, 1'b1, 4'b1111, 4'b1110}, // R6 clear
    {4'd6, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1101}, // R6 toggle x4
    {4'd6, 1'b1, 1'b1, 1'b1, 4'b1111, 4'b1010},
    {4'd6, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b0101},
    {4'd6, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1010},
    {4'd4, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0000}, // R4 load zero with J set
    {4'd5, 1'b1, 1'b1, 1'b0, 4'b1111, 4'b0001}, // R5 shift chain
    {4'd5, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0011},
    {4'd5, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0111},
    {4'd5, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b1110},
    {4'd5, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1100}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_inv(input logic [W-1:0] qq, input logic inv);
    checks++;
    if (inv !== ~qq[W-1]) begin
      errors++;
      $display("FAIL R7: q_last_n actual=%b expected=%b", inv, ~qq[W-1]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2 clr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", q, '0);
    check_inv(q, q_last_n);
    clr_n = 1'b1;

    // vector table
    for (int n = 0; n < NV; n++) begin
      {shift_en, j_in, k_in, par_d} = VEC[n][10:4];
      @(negedge clk);
      check($sformatf("R%0d", VEC[n][14:11]), q, VEC[n][3:0]);
      check_inv(q, q_last_n);
    end

    // R1: mid-cycle clear without a clock edge
    shift_en = 1'b0; par_d = 4'b1111;
    @(negedge clk);
    check("R3", q, 4'b1111);
    check_inv(q, q_last_n);
    #1 clr_n = 1'b0;
    #1 check("R1", q, 4'b0000);
    check_inv(q, q_last_n);

    // R2: edges during clear do nothing
    shift_en = 1'b0; par_d = 4'b1011; j_in = 1'b1; k_in = 1'b0;
    @(negedge clk);
    check("R2", q, 4'b0000);
    shift_en = 1'b1;
    @(negedge clk);
    check("R2", q, 4'b0000);
    clr_n = 1'b1;

    // R8: active-low K instance in D mode, shift in 1,0,1,1
    shift2 = 1'b1;
    din2 = 1'b1; @(negedge clk); check("R8", q2, 4'b0001);
    din2 = 1'b0; @(negedge clk); check("R8", q2, 4'b0010);
    din2 = 1'b1; @(negedge clk); check("R8", q2, 4'b0101);
    din2 = 1'b1; @(negedge clk); check("R8", q2, 4'b1011);
    check_inv(q2, q2_last_n);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule